// File: doc/BRIEF.md
# Video Line and Frame Sequencer

This block derives video line and frame timing from the system clock. A fixed-point phase accumulator with twelve fractional bits sets the length of each line, so the average line period can be a non-integer number of clocks (about 2146.31 clocks in the 60 Hz standard and about 2164.14 in the 50 Hz standard with the default increments). Whenever a line ends, a one-clock line tick is produced. The same tick can serve as a clock source for a general-purpose timer.

A line counter steps through a frame of 263 lines (60 Hz standard) or 313 lines (50 Hz standard). When the counter enters line 240, a vertical-blank level goes high and a one-clock vertical-blank interrupt pulse is issued. When the frame ends, the line counter returns to zero, the blank level drops and a frame counter advances. If both interlace control bits are set, an odd/even field bit is also refreshed at that point. The standard select input is sampled only at reset and at frame boundaries.

Top module: `video_line_sequencer`

## Requirements
- R1: The period of each line is floor((F + I) / 2^FRAC_BITS) clocks. I is the increment of the active standard (default 8791293 for `stdSel`=0 and 8864320 for `stdSel`=1). F is the fraction left over from the previous line. The low FRAC_BITS bits of F + I become the new F.
- R2: `hsyncTick` is high for exactly one clock. It rises in the same cycle that `lineNum` takes its new value. The number of clocks between consecutive ticks equals the period of the line that just ended.
- R3: `lineNum` counts 0 to STD0_LINES-1 (263 lines) when the active standard is 0 and 0 to STD1_LINES-1 (313 lines) when it is 1. After the last line it wraps to 0.
- R4: `vblankIrq` is a single-clock pulse, issued only together with the tick that moves `lineNum` to VBLANK_LINE (240).
- R5: `vblank` goes high when `lineNum` enters VBLANK_LINE. It stays high until `lineNum` returns to 0.
- R6: `frameCount` increments by one, modulo 2^FRAME_W, with each line-counter wrap, and at no other time.
- R7: At a wrap with `ilaceCtl` equal to 2'b11, `fieldBit` takes bit 0 of the new `frameCount`. At a wrap with any other `ilaceCtl` value, `fieldBit` holds its value. It never changes between wraps.
- R8: A change on `stdSel` has no effect on the line count or line period until the next frame boundary. From that boundary on, line 0 and the rest of the frame use the new standard.
- R9: Synchronous reset clears `lineNum`, `frameCount`, `vblank`, `vblankIrq`, `hsyncTick`, `fieldBit` and the fraction. It samples `stdSel`, so the first line after reset lasts floor(I / 2^FRAC_BITS) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| stdSel | input | 1 | Standard select: 0 = 60 Hz (263 lines), 1 = 50 Hz (313 lines) |
| ilaceCtl | input | 2 | Interlace control; field bit is refreshed only when both bits are set |
| hsyncTick | output | 1 | One-clock pulse at each line start |
| lineNum | output | LINE_W | Current line number |
| vblank | output | 1 | Vertical-blank level |
| vblankIrq | output | 1 | One-clock vertical-blank interrupt pulse |
| fieldBit | output | 1 | Odd/even field status |
| frameCount | output | FRAME_W | Frame counter |

## Verification
The hardest situations to reach from the ports occur at the boundaries between frames. One is a standard change that arrives in the middle of a frame, where the fraction left by the old standard must carry into line 0 of the new one. Another is the wrap of the frame counter, which at default sizes takes an enormous number of clocks. The bench therefore scales the block down to frames of 10 and 12 lines, with increments of 3.25 and 4.5 clocks. It then switches `stdSel` and `ilaceCtl` partway through frames, and checks every tick against a reference model that it carries itself. The model tracks the fraction, the standard latch and a 3-bit frame counter, so carries and wraps show up within a few hundred clocks.

// File: rtl/vls_pkg.sv
package vls_pkg;

  // Strobes from the line control to the phase datapath.
  typedef struct packed {
    logic advance;  // end of the current line: reload the clock counter
    logic altStd;   // standard whose increment applies to the next line
  } seqStrobe_t;

endpackage

// File: rtl/vls_phase_dp.sv
module vls_phase_dp
  import vls_pkg::*;
#(
  parameter int          FRAC_BITS = 12,
  parameter int          PER_W     = 16,
  parameter int unsigned STD0_INC  = 8791293,
  parameter int unsigned STD1_INC  = 8864320
) (
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strobe,
  output logic       lineDone
);

  localparam int ACC_W = FRAC_BITS + PER_W;
  localparam logic [ACC_W-1:0] INC0 = ACC_W'(STD0_INC);
  localparam logic [ACC_W-1:0] INC1 = ACC_W'(STD1_INC);

  logic [FRAC_BITS-1:0] frac;
  logic [PER_W-1:0]     period;
  logic [PER_W-1:0]     clkCnt;
  logic [ACC_W-1:0]     incVal;
  logic [ACC_W-1:0]     accSum;

  // Increment of the standard chosen for the next line.
  always_comb begin
    incVal = strobe.altStd ? INC1 : INC0;
    accSum = {{PER_W{1'b0}}, frac} + incVal;
  end

  // The clock counter runs 0 .. period-1; the last count ends the line.
  assign lineDone = (clkCnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      clkCnt <= '0;
      frac   <= incVal[FRAC_BITS-1:0];
      period <= incVal[ACC_W-1:FRAC_BITS];
    end else if (strobe.advance) begin
      clkCnt <= '0;
      frac   <= accSum[FRAC_BITS-1:0];
      period <= accSum[ACC_W-1:FRAC_BITS];
    end else begin
      clkCnt <= clkCnt + 1'b1;
    end
  end

  // R1: every line must have at least one clock
  p_period_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
    period != '0);

  // R2: the counter never runs past the line period
  p_cnt_in_line_r2: assert property (@(posedge clk) disable iff (rst)
    clkCnt < period);

  // R1: a line that is not ending keeps its period
  p_period_held_r1: assert property (@(posedge clk) disable iff (rst)
    !strobe.advance |=> $stable(period));

endmodule

// File: rtl/vls_line_ctrl.sv
module vls_line_ctrl
  import vls_pkg::*;
#(
  parameter int STD0_LINES  = 263,
  parameter int STD1_LINES  = 313,
  parameter int VBLANK_LINE = 240,
  parameter int FRAME_W     = 16,
  parameter int LINE_W      = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stdSel,
  input  logic [1:0]         ilaceCtl,
  input  logic               lineDone,
  output seqStrobe_t         strobe,
  output logic               hsyncTick,
  output logic [LINE_W-1:0]  lineNum,
  output logic               vblank,
  output logic               vblankIrq,
  output logic               fieldBit,
  output logic [FRAME_W-1:0] frameCount
);

  localparam logic [LINE_W-1:0] TOTAL0 = LINE_W'(STD0_LINES);
  localparam logic [LINE_W-1:0] TOTAL1 = LINE_W'(STD1_LINES);
  localparam logic [LINE_W-1:0] VB_AT  = LINE_W'(VBLANK_LINE);

  logic                stdReg;
  logic [LINE_W-1:0]   totalCur;
  logic [LINE_W-1:0]   nextLine;
  logic [FRAME_W-1:0]  nextFrame;
  logic                wrap;
  logic                nextStd;

  always_comb begin
    totalCur  = stdReg ? TOTAL1 : TOTAL0;
    nextLine  = lineNum + 1'b1;
    nextFrame = frameCount + 1'b1;
    wrap      = lineDone && (nextLine == totalCur);
    // The standard input is taken only at reset or at a frame boundary.
    nextStd   = (rst || wrap) ? stdSel : stdReg;
  end

  always_comb begin
    strobe.advance = lineDone;
    strobe.altStd  = nextStd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stdReg     <= stdSel;
      lineNum    <= '0;
      frameCount <= '0;
      vblank     <= 1'b0;
      vblankIrq  <= 1'b0;
      hsyncTick  <= 1'b0;
      fieldBit   <= 1'b0;
    end else begin
      hsyncTick <= lineDone;
      vblankIrq <= 1'b0;
      if (lineDone) begin
        if (wrap) begin
          lineNum    <= '0;
          frameCount <= nextFrame;
          vblank     <= 1'b0;
          stdReg     <= stdSel;
          if (ilaceCtl == 2'b11) begin
            fieldBit <= nextFrame[0];
          end
        end else begin
          lineNum <= nextLine;
          if (nextLine == VB_AT) begin
            vblank    <= 1'b1;
            vblankIrq <= 1'b1;
          end
        end
      end
    end
  end

  // R3: the line number stays inside the active frame
  p_line_bound_r3: assert property (@(posedge clk) disable iff (rst)
    lineNum < totalCur);

  // R4: the interrupt comes only with the tick that enters the blank line
  p_irq_at_line_r4: assert property (@(posedge clk) disable iff (rst)
    vblankIrq |-> (hsyncTick && lineNum == VB_AT));

  // R4: the interrupt is a single-clock pulse
  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    vblankIrq |=> !vblankIrq);

  // R5: blank rises on the blank line and falls on line 0
  p_vb_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vblank) |-> lineNum == VB_AT);
  p_vb_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(vblank) |-> lineNum == '0);

  // R6: a new frame is exactly one count ahead of the previous cycle
  p_frame_step_r6: assert property (@(posedge clk) disable iff (rst)
    (hsyncTick && lineNum == '0) |-> frameCount == FRAME_W'($past(frameCount) + 1'b1));

  // R7: the field bit moves only at a frame start
  p_field_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(fieldBit) |-> (hsyncTick && lineNum == '0));

  // R8: the latched standard moves only at a frame start
  p_std_frame_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(stdReg) |-> (hsyncTick && lineNum == '0));

endmodule

// File: rtl/video_line_sequencer.sv
module video_line_sequencer
  import vls_pkg::*;
#(
  parameter int          FRAC_BITS   = 12,
  parameter int          PER_W       = 16,
  parameter int unsigned STD0_INC    = 8791293,
  parameter int unsigned STD1_INC    = 8864320,
  parameter int          STD0_LINES  = 263,
  parameter int          STD1_LINES  = 313,
  parameter int          VBLANK_LINE = 240,
  parameter int          FRAME_W     = 16,
  parameter int          LINE_W      = $clog2(((STD0_LINES > STD1_LINES) ? STD0_LINES : STD1_LINES) + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stdSel,
  input  logic [1:0]         ilaceCtl,
  output logic               hsyncTick,
  output logic [LINE_W-1:0]  lineNum,
  output logic               vblank,
  output logic               vblankIrq,
  output logic               fieldBit,
  output logic [FRAME_W-1:0] frameCount
);

  seqStrobe_t strobe;
  logic       lineDone;

  vls_phase_dp #(
    .FRAC_BITS (FRAC_BITS),
    .PER_W     (PER_W),
    .STD0_INC  (STD0_INC),
    .STD1_INC  (STD1_INC)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .lineDone (lineDone)
  );

  vls_line_ctrl #(
    .STD0_LINES  (STD0_LINES),
    .STD1_LINES  (STD1_LINES),
    .VBLANK_LINE (VBLANK_LINE),
    .FRAME_W     (FRAME_W),
    .LINE_W      (LINE_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .stdSel     (stdSel),
    .ilaceCtl   (ilaceCtl),
    .lineDone   (lineDone),
    .strobe     (strobe),
    .hsyncTick  (hsyncTick),
    .lineNum    (lineNum),
    .vblank     (vblank),
    .vblankIrq  (vblankIrq),
    .fieldBit   (fieldBit),
    .frameCount (frameCount)
  );

endmodule

// File: tb/video_line_sequencer_test.sv
`timescale 1ns/1ps
module video_line_sequencer_test;

  // Scaled-down timing so that many frames pass quickly.
  localparam int FRAC   = 12;
  localparam int INC0   = 13312;   // 3.25 clocks per line
  localparam int INC1   = 18432;   // 4.5 clocks per line
  localparam int LINES0 = 10;
  localparam int LINES1 = 12;
  localparam int VBL    = 7;
  localparam int FW     = 3;
  localparam int LW     = $clog2(LINES1 + 1);

  typedef struct packed {
    bit       pal;
    bit [1:0] ilace;
    bit [7:0] ticks;
  } seg_t;

  localparam int NSEG = 5;
  localparam seg_t SEGS [NSEG] = '{
    '{1'b0, 2'b00, 8'd25},
    '{1'b1, 2'b11, 8'd30},
    '{1'b1, 2'b11, 8'd24},
    '{1'b0, 2'b01, 8'd30},
    '{1'b0, 2'b11, 8'd20}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stdSel = 1'b0;
  logic [1:0]    ilaceCtl = 2'b00;
  logic          hsyncTick, vblank, vblankIrq, fieldBit;
  logic [LW-1:0] lineNum;
  logic [FW-1:0] frameCount;

  video_line_sequencer #(
    .FRAC_BITS (FRAC), .PER_W (8), .STD0_INC (INC0), .STD1_INC (INC1),
    .STD0_LINES (LINES0), .STD1_LINES (LINES1), .VBLANK_LINE (VBL),
    .FRAME_W (FW), .LINE_W (LW)
  ) uut (
    .clk (clk), .rst (rst), .stdSel (stdSel), .ilaceCtl (ilaceCtl),
    .hsyncTick (hsyncTick), .lineNum (lineNum), .vblank (vblank),
    .vblankIrq (vblankIrq), .fieldBit (fieldBit), .frameCount (frameCount)
  );

  always #4 clk = ~clk;   // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  hung    = 1'b0;
  int  lastTick;

  // Reference model state
  int mStd, mFrac, mPeriod, mLine, mFrame, mVb, mField, mIrq;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int incOf(input int s);
    return (s != 0) ? INC1 : INC0;
  endfunction

  task automatic modelReset(input int s);
    int sum;
    mStd = s; sum = incOf(s);
    mPeriod = sum >> FRAC; mFrac = sum & ((1 << FRAC) - 1);
    mLine = 0; mFrame = 0; mVb = 0; mField = 0; mIrq = 0;
  endtask

  // Advance the model by one line, with the inputs held during the wait.
  task automatic modelStep(input int s, input int il);
    int nl, tot, sum;
    tot = (mStd != 0) ? LINES1 : LINES0;
    nl  = mLine + 1;
    mIrq = 0;
    if (nl == tot) begin
      mLine = 0; mFrame = (mFrame + 1) % (1 << FW); mVb = 0; mStd = s;
      if (il == 3) mField = mFrame & 1;
    end else begin
      mLine = nl;
      if (nl == VBL) begin mVb = 1; mIrq = 1; end
    end
    sum = mFrac + incOf(mStd);
    mPeriod = sum >> FRAC; mFrac = sum & ((1 << FRAC) - 1);
  endtask

  // Wait for the next tick; acts as the watchdog for a stalled design.
  task automatic waitTick(output int gap);
    int waited = 0;
    gap = 0;
    do begin
      @(negedge clk);
      waited++;
      if (vblankIrq && !hsyncTick) chk("R4 irq without tick", 1, 0);
      if (waited > 64 || cyc > 150000) begin
        chk("watchdog tick timeout", 0, 1);
        hung = 1'b1;
        return;
      end
    end while (!hsyncTick);
    gap = cyc - lastTick;
    lastTick = cyc;
  endtask

  task automatic runTicks(input int n);
    int gap, expGap;
    for (int k = 0; k < n && !hung; k++) begin
      expGap = mPeriod;
      waitTick(gap);
      if (hung) return;
      modelStep(int'(stdSel), int'(ilaceCtl));
      chk("R1 R2 tick interval", gap, expGap);
      chk("R3 R8 line number", int'(lineNum), mLine);
      chk("R5 vblank level", int'(vblank), mVb);
      chk("R4 vblank irq", int'(vblankIrq), mIrq);
      chk("R6 frame count", int'(frameCount), mFrame);
      chk("R7 field bit", int'(fieldBit), mField);
    end
  endtask

  task automatic checkResetState();
    chk("R9 reset lineNum", int'(lineNum), 0);
    chk("R9 reset frameCount", int'(frameCount), 0);
    chk("R9 reset vblank", int'(vblank), 0);
    chk("R9 reset irq", int'(vblankIrq), 0);
    chk("R9 reset tick", int'(hsyncTick), 0);
    chk("R9 reset field", int'(fieldBit), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkResetState();
    rst = 1'b0;
    lastTick = cyc;
    modelReset(0);

    // Table of segments, each switching inputs partway through a frame.
    for (int s = 0; s < NSEG && !hung; s++) begin
      stdSel   = SEGS[s].pal;
      ilaceCtl = SEGS[s].ilace;
      runTicks(int'(SEGS[s].ticks));
    end

    // Directed: mid-frame reset with the 50 Hz standard selected; the
    // fraction must restart at zero (first periods 4 then 5 clocks).
    if (!hung) begin
      @(negedge clk);
      rst = 1'b1; stdSel = 1'b1; ilaceCtl = 2'b11;
      repeat (2) @(negedge clk);
      checkResetState();
      rst = 1'b0;
      lastTick = cyc;
      modelReset(1);
      chk("R9 first period after reset", mPeriod, 4);
      runTicks(14);
    end

    // Directed: standard flip one line before the wrap is ignored for that frame.
    if (!hung) begin
      stdSel = 1'b0;
      while (!hung && mLine != LINES1 - 2) runTicks(1);
      stdSel = 1'b1;
      runTicks(1);
      chk("R8 line before wrap", int'(lineNum), LINES1 - 1);
      stdSel = 1'b0;
      runTicks(1);
      chk("R8 wrap to zero", int'(lineNum), 0);
      runTicks(LINES0);
      chk("R3 R8 new standard frame", int'(lineNum), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule